// File: doc/BRIEF.md
# Carry-Save Tree Multioperand Adder

This block sums a parameterised number of unsigned operands. All of them arrive in parallel on one packed input bus. A tree of 3:2 carry-save stages reduces the operand rows to two vectors. A single ripple-carry adder then resolves those two vectors into the full-width result.

At every level of the tree, each complete group of three rows is compressed at once. Rows that do not fill a group pass straight to the next level. The number of levels is therefore the smallest height whose maximal operand capacity covers the operand count. With the default of seven 6-bit operands, the row counts per level are 7, 5, 4, 3 and 2, which is four carry-save levels.

An optional output register, enabled by default, holds the result for one clock. The register has an active-low asynchronous reset.

Top module: `csa_tree_adder`

## Requirements
- R1: `sum_o` equals the exact unsigned sum of all `NUM_OPS` operands, where operand i occupies bits `[i*OP_W +: OP_W]` of `ops_i`.
- R2: The result width is `OP_W + $clog2(NUM_OPS)` bits (9 by default). With every operand at its maximum value, the sum `NUM_OPS*(2^OP_W-1)` (441 by default) appears without loss.
- R3: Every 3:2 stage preserves value (x+y+z = s + 2c, with the carry vector moved up one bit and a zero in its lowest bit). As a result, the true sum of the live rows at each tree level equals the operand sum.
- R4: For a level with r live rows, the next level has 2*floor(r/3) + r mod 3 live rows, and all other row slots are zero. Seven operands reach two rows after exactly four levels.
- R5: The two rows that leave the tree never overflow the final ripple-carry adder: their sum fits in the result width.
- R6: With `OUT_REG`=1, `sum_o` shows the sum of the operands sampled at the previous rising clock edge. While `rst_ni` is low, `sum_o` is zero.
- R7: All-zero operands give a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ops_i | input | NUM_OPS*OP_W | Packed operands, operand 0 in the low bits |
| sum_o | output | OP_W+$clog2(NUM_OPS) | Sum of all operands |

## Verification
The bench drives all-zero sets, all-ones sets, a single maximal operand in each slot, alternating bit patterns that make every carry-save column generate carries, and several thousand random sets. It compares each result with an integer sum that trails the inputs by one clock.

A tree that dropped a leftover row would come up short by exactly that operand on the single-slot patterns. A carry vector that was not shifted would give sums that are wrong whenever two operands share a set bit. A result that is too narrow would wrap on the all-ones set.

The assertions check, on every cycle, that each level preserves the total and that unused row slots stay empty.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;

  // live rows after one Wallace level
  function automatic int rows_next(input int r);
    return 2 * (r / 3) + (r % 3);
  endfunction

  // live rows at tree level l for n operands
  function automatic int rows_at(input int n, input int l);
    int r;
    r = n;
    for (int i = 0; i < l; i++) r = rows_next(r);
    return r;
  endfunction

  // levels needed to reach two rows
  function automatic int tree_levels(input int n);
    int r;
    int h;
    r = n;
    h = 0;
    while (r > 2) begin
      r = rows_next(r);
      h++;
    end
    return h;
  endfunction

  // largest operand count an h-level tree brings to two rows
  function automatic int max_ops(input int h);
    int m;
    m = 2;
    for (int i = 0; i < h; i++) m = (m * 3) / 2;
    return m;
  endfunction

endpackage

// File: rtl/csa_stage.sv
module csa_stage #(
  parameter int W = 9
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  // one full adder per column, no ripple; carry pre-shifted to weight 2
  assign sum_o = x_i ^ y_i ^ z_i;
  assign carry_o[0] = 1'b0;
  assign carry_o[W-1:1] = (x_i[W-2:0] & y_i[W-2:0]) |
                          (x_i[W-2:0] & z_i[W-2:0]) |
                          (y_i[W-2:0] & z_i[W-2:0]);
endmodule

// File: rtl/csa_level.sv
module csa_level #(
  parameter int IN_ROWS  = 7,
  parameter int MAX_ROWS = 7,
  parameter int W        = 9
) (
  input  logic [IN_ROWS-1:0][W-1:0]  rows_i,
  output logic [MAX_ROWS-1:0][W-1:0] rows_o
);
  localparam int GROUPS   = IN_ROWS / 3;
  localparam int LEFT     = IN_ROWS % 3;
  localparam int OUT_ROWS = 2 * GROUPS + LEFT;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    csa_stage #(.W(W)) u_stage (
      .x_i    (rows_i[3*g]),
      .y_i    (rows_i[3*g+1]),
      .z_i    (rows_i[3*g+2]),
      .sum_o  (rows_o[2*g]),
      .carry_o(rows_o[2*g+1])
    );
  end

  for (genvar j = 0; j < LEFT; j++) begin : g_pass
    assign rows_o[2*GROUPS+j] = rows_i[3*GROUPS+j];
  end

  for (genvar e = OUT_ROWS; e < MAX_ROWS; e++) begin : g_zero
    assign rows_o[e] = '0;
  end
endmodule

// File: rtl/rca_adder.sv
module rca_adder #(
  parameter int W = 9
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] cy;

  assign cy[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
    if (i < W - 1) begin : g_cy
      assign cy[i+1] = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
    end
  end
endmodule

// File: rtl/csa_tree_adder.sv
module csa_tree_adder
  import csa_tree_pkg::*;
#(
  parameter int NUM_OPS = 7,
  parameter int OP_W    = 6,
  parameter bit OUT_REG = 1'b1,
  localparam int SUM_W  = OP_W + $clog2(NUM_OPS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_OPS*OP_W-1:0] ops_i,
  output logic [SUM_W-1:0]        sum_o
);
  localparam int LEVELS = tree_levels(NUM_OPS);

  logic [NUM_OPS-1:0][SUM_W-1:0] lvl_rows [LEVELS+1];
  logic [SUM_W-1:0]              cpa_sum;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_in
    assign lvl_rows[0][i] = {{(SUM_W-OP_W){1'b0}}, ops_i[i*OP_W +: OP_W]};
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int IN_ROWS = rows_at(NUM_OPS, l);
    csa_level #(
      .IN_ROWS (IN_ROWS),
      .MAX_ROWS(NUM_OPS),
      .W       (SUM_W)
    ) u_level (
      .rows_i(lvl_rows[l][IN_ROWS-1:0]),
      .rows_o(lvl_rows[l+1])
    );
  end

  rca_adder #(.W(SUM_W)) u_cpa (
    .a_i  (lvl_rows[LEVELS][0]),
    .b_i  (lvl_rows[LEVELS][1]),
    .sum_o(cpa_sum)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sum_o <= '0;
      else         sum_o <= cpa_sum;
    end
  end else begin : g_comb
    assign sum_o = cpa_sum;
  end
endmodule

// File: rtl/csa_tree_adder_chk.sv
module csa_tree_adder_chk
  import csa_tree_pkg::*;
#(
  parameter int NUM_OPS = 7,
  parameter int OP_W    = 6,
  parameter bit OUT_REG = 1'b1,
  localparam int SUM_W  = OP_W + $clog2(NUM_OPS),
  localparam int LEVELS = tree_levels(NUM_OPS)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_OPS*OP_W-1:0]       ops_i,
  input logic [SUM_W-1:0]              sum_o,
  input logic [NUM_OPS-1:0][SUM_W-1:0] lvl_rows [LEVELS+1]
);
  function automatic int op_total(input logic [NUM_OPS*OP_W-1:0] v);
    int t;
    t = 0;
    for (int i = 0; i < NUM_OPS; i++) t += int'(v[i*OP_W +: OP_W]);
    return t;
  endfunction

  function automatic int row_total(input logic [NUM_OPS-1:0][SUM_W-1:0] v);
    int t;
    t = 0;
    for (int i = 0; i < NUM_OPS; i++) t += int'(v[i]);
    return t;
  endfunction

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lv
    // R3
    level_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      row_total(lvl_rows[l]) == op_total(ops_i));
    for (genvar r = rows_at(NUM_OPS, l); r < NUM_OPS; r++) begin : g_idle
      // R4
      idle_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_rows[l][r] == '0);
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(lvl_rows[LEVELS][0]) + int'(lvl_rows[LEVELS][1])) < (1 << SUM_W));

  if (OUT_REG) begin : g_reg
    // R1 R6
    sum_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> int'(sum_o) == op_total($past(ops_i)));
  end else begin : g_comb
    // R1
    sum_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(sum_o) == op_total(ops_i));
  end
endmodule

bind csa_tree_adder csa_tree_adder_chk #(
  .NUM_OPS(NUM_OPS),
  .OP_W   (OP_W),
  .OUT_REG(OUT_REG)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ops_i   (ops_i),
  .sum_o   (sum_o),
  .lvl_rows(lvl_rows)
);

// File: tb/tb_csa_tree_adder.sv
module tb_csa_tree_adder;
  localparam int N     = 7;
  localparam int K     = 6;
  localparam int SUM_W = K + $clog2(N);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N*K-1:0]   ops_i = '0;
  logic [SUM_W-1:0] sum_o;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];

  csa_tree_adder #(.NUM_OPS(N), .OP_W(K), .OUT_REG(1'b1)) dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ops_i (ops_i),
    .sum_o (sum_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic int ref_sum(input logic [N*K-1:0] v);
    int t;
    t = 0;
    for (int i = 0; i < N; i++) t += int'(v[i*K +: K]);
    return t;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: sum_o=%0d expected=%0d", req, act, exp);
    end
  endtask

  // at negedge: check result of previous operands, then apply new ones
  task automatic step(input string req, input logic [N*K-1:0] v);
    @(negedge clk_i);
    if (exp_q.size() > 0) check(req, int'(sum_o), exp_q.pop_front());
    ops_i = v;
    exp_q.push_back(ref_sum(v));
  endtask

  initial begin
    logic [N*K-1:0] v;
    repeat (3) @(negedge clk_i);
    // R6 reset state
    check("R6", int'(sum_o), 0);
    ops_i = '1;
    @(negedge clk_i);
    check("R6", int'(sum_o), 0);
    rst_ni = 1'b1;
    ops_i  = '0;
    exp_q.push_back(0);

    // R7 zeros
    step("R7", '0);
    step("R7", '0);
    // R2 all ones, 441
    step("R2", '1);
    step("R2", '1);
    // R4 single max operand in each slot, incl. leftover rows
    for (int i = 0; i < N; i++) begin
      v = '0;
      v[i*K +: K] = '1;
      step("R4", v);
    end
    // R3 alternating patterns load every column with carries
    for (int i = 0; i < N * K; i++) v[i] = i[0];
    step("R3", v);
    step("R3", ~v);
    for (int i = 0; i < N; i++) v[i*K +: K] = 6'b010101;
    step("R3", v);
    // R1 random sets
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < N; i++) v[i*K +: K] = K'($urandom);
      step("R1", v);
    end
    step("R7", '0);
    step("R2", '1);
    step("R1", '0);
    // R6 async reset clears mid-run
    @(negedge clk_i);
    void'(exp_q.pop_front());
    ops_i = '1;
    #3 rst_ni = 1'b0;
    #2 check("R6", int'(sum_o), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog: sum_o=%0d expected=done", int'(sum_o));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule